// File: doc/BRIEF.md
# Programmable Memory and I/O Chip Selector

This block turns each bus cycle's address into active-low chip selects for external memories and peripherals. Software loads five configuration registers through a simple write port; each register describes one decode window: a block at the top of the 1-Mbyte memory space, a block at the bottom, a mid-range region split into four equal quarters, and a 1-Kbyte peripheral area in the 64-Kbyte I/O space split into 128-byte slots.

The address is sampled when the address strobe is high and bus hold is low. The selects are registered and stay stable for the rest of the bus cycle. Two peripheral outputs can instead carry latched copies of address bits 1 and 2. During bus hold the block keeps driving every output and ignores the strobe, so the latched address bits keep their last value.

Top module: `chip_sel_top`

## Requirements
- R1: After reset every output is high, and every window stays disabled until its register is written.
- R2: Register 0 (bit 15 enable, bits 3:0 size code k, block = 1K<<k) drives ucs_no low on a memory cycle when k<=8 and address bits 19:(10+k) are all ones.
- R3: Register 1 (same layout as register 0) drives lcs_no low on a memory cycle when k<=8 and address bits 19:(10+k) are all zero.
- R4: Register 2 (bit 15 enable, bits 10:8 size code k, region = 8K<<k, bits 6:0 base = address bits 19:13) drives mcs_no[i] low on a memory cycle inside the region, where i is the quarter index, address bits (12+k):(11+k).
- R5: A size code above 8 for registers 0 and 1, or above 6 for register 2, or a register 2 base with any of its k low bits set, disables that window.
- R6: At most one memory select is low; the upper window wins over the lower window, and both win over the mid-range region.
- R7: Register 3 (bit 15 enable, bits 5:0 = I/O address bits 15:10) drives pcs_no[n] low on an I/O cycle when n = address bits 9:7 and n<7. Memory selects stay high on I/O cycles and peripheral selects stay high on memory cycles.
- R8: Register 4 bit 0 makes pcs_no[5] carry address bit 1, and bit 1 makes pcs_no[6] carry address bit 2, both latched at the strobe on any cycle type. Register addresses 5 to 7 are ignored.
- R9: Outputs change only on a clock edge where ale_i is high and hold_i is low. A register write in that same cycle affects only later strobes.
- R10: While hold_i is high, ale_i is ignored and every output, including latched address bits, keeps driving its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_data_i | input | 16 | Configuration write data |
| addr_i | input | 20 | Bus cycle address |
| ale_i | input | 1 | Address strobe, samples addr_i and mem_io_i |
| mem_io_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| hold_i | input | 1 | Bus hold active |
| ucs_no | output | 1 | Upper memory select, active low |
| lcs_no | output | 1 | Lower memory select, active low |
| mcs_no | output | 4 | Mid-range memory selects, active low |
| pcs_no | output | 7 | Peripheral selects or latched A1/A2, active low |

## Verification
A register write and an address strobe can land in the same cycle. The bench provokes this with directed cases that move a window with the same write that strobes an address inside the old window and outside the new one. It also does this at random throughout the run. The bench expects the decode to use the configuration from before the write and to switch only at the next strobe. The same reasoning covers a strobe under hold, which must leave the outputs as they were.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CFG_DW = 16;
  localparam int CFG_AW = 3;

  localparam logic [CFG_AW-1:0] REG_UP  = 3'd0;
  localparam logic [CFG_AW-1:0] REG_LO  = 3'd1;
  localparam logic [CFG_AW-1:0] REG_MID = 3'd2;
  localparam logic [CFG_AW-1:0] REG_PIO = 3'd3;
  localparam logic [CFG_AW-1:0] REG_MOD = 3'd4;

  typedef struct packed {
    logic       en;
    logic [3:0] k;
  } win_cfg_t;

  typedef struct packed {
    logic       en;
    logic [2:0] k;
    logic [6:0] base;
  } mid_cfg_t;

  typedef struct packed {
    logic       en;
    logic [5:0] base;
  } pio_cfg_t;
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] waddr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output win_cfg_t          up_o,
  output win_cfg_t          lo_o,
  output mid_cfg_t          mid_o,
  output pio_cfg_t          pio_o,
  output logic [1:0]        lat_o
);
  logic unused_bits;
  assign unused_bits = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o  <= '0;
      lo_o  <= '0;
      mid_o <= '0;
      pio_o <= '0;
      lat_o <= '0;
    end else if (we_i) begin
      case (waddr_i)
        REG_UP:  up_o  <= '{en: wdata_i[15], k: wdata_i[3:0]};
        REG_LO:  lo_o  <= '{en: wdata_i[15], k: wdata_i[3:0]};
        REG_MID: mid_o <= '{en: wdata_i[15], k: wdata_i[10:8], base: wdata_i[6:0]};
        REG_PIO: pio_o <= '{en: wdata_i[15], base: wdata_i[5:0]};
        REG_MOD: lat_o <= wdata_i[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cs_mem_decode.sv
module cs_mem_decode
  import cs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WIN_SH = 10,
  parameter int MID_SH = 13,
  parameter int N_MID  = 4,
  parameter int WIN_KMAX = 8,
  parameter int MID_KMAX = 6
) (
  input  win_cfg_t           up_i,
  input  win_cfg_t           lo_i,
  input  mid_cfg_t           mid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               ucs_hit_o,
  output logic               lcs_hit_o,
  output logic [N_MID-1:0]   mcs_hit_o
);
  localparam int IDX_W = $clog2(N_MID);
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] up_mask, lo_mask, mid_mask, mid_base;
  logic              up_hit, lo_hit, mid_hit, mid_ok;
  logic [IDX_W-1:0]  mid_idx;

  always_comb begin
    up_mask  = ONES << (WIN_SH + 32'(up_i.k));
    lo_mask  = ONES << (WIN_SH + 32'(lo_i.k));
    mid_mask = ONES << (MID_SH + 32'(mid_i.k));
    mid_base = ADDR_W'(mid_i.base) << MID_SH;
    mid_ok   = mid_i.en && (32'(mid_i.k) <= MID_KMAX) && ((mid_base & ~mid_mask) == '0);
    up_hit   = up_i.en && (32'(up_i.k) <= WIN_KMAX) && ((addr_i & up_mask) == up_mask);
    lo_hit   = lo_i.en && (32'(lo_i.k) <= WIN_KMAX) && ((addr_i & lo_mask) == '0);
    mid_hit  = mid_ok && ((addr_i & mid_mask) == mid_base);
    mid_idx  = IDX_W'(addr_i >> (MID_SH - IDX_W + 32'(mid_i.k)));
  end

  // upper > lower > mid
  assign ucs_hit_o = up_hit;
  assign lcs_hit_o = lo_hit && !up_hit;

  for (genvar g = 0; g < N_MID; g++) begin : g_mid
    assign mcs_hit_o[g] = mid_hit && !up_hit && !lo_hit && (mid_idx == IDX_W'(g));
  end
endmodule

// File: rtl/cs_io_decode.sv
module cs_io_decode
  import cs_pkg::*;
#(
  parameter int IO_W   = 16,
  parameter int BLK_SH = 10,
  parameter int SUB_SH = 7,
  parameter int N_PCS  = 7
) (
  input  pio_cfg_t          pio_i,
  input  logic [IO_W-1:0]   addr_i,
  output logic [N_PCS-1:0]  pcs_hit_o
);
  localparam int IDX_W = BLK_SH - SUB_SH;

  logic             blk_hit;
  logic [IDX_W-1:0] slot;

  assign blk_hit = pio_i.en && (addr_i[IO_W-1:BLK_SH] == pio_i.base);
  assign slot    = addr_i[BLK_SH-1:SUB_SH];

  for (genvar g = 0; g < N_PCS; g++) begin : g_pcs
    assign pcs_hit_o[g] = blk_hit && (slot == IDX_W'(g));
  end
endmodule

// File: rtl/chip_sel_top.sv
module chip_sel_top
  import cs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int N_MID  = 4,
  parameter int N_PCS  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ale_i,
  input  logic              mem_io_i,
  input  logic              hold_i,
  output logic              ucs_no,
  output logic              lcs_no,
  output logic [N_MID-1:0]  mcs_no,
  output logic [N_PCS-1:0]  pcs_no
);
  localparam int A1_IDX = N_PCS - 2;
  localparam int A2_IDX = N_PCS - 1;

  win_cfg_t         up_cfg, lo_cfg;
  mid_cfg_t         mid_cfg;
  pio_cfg_t         pio_cfg;
  logic [1:0]       lat_cfg;
  logic             ucs_hit, lcs_hit;
  logic [N_MID-1:0] mcs_hit;
  logic [N_PCS-1:0] pcs_hit, pcs_nxt;
  logic             take;

  cs_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i),
    .up_o    (up_cfg),
    .lo_o    (lo_cfg),
    .mid_o   (mid_cfg),
    .pio_o   (pio_cfg),
    .lat_o   (lat_cfg)
  );

  cs_mem_decode #(.ADDR_W(ADDR_W), .N_MID(N_MID)) u_mem (
    .up_i      (up_cfg),
    .lo_i      (lo_cfg),
    .mid_i     (mid_cfg),
    .addr_i    (addr_i),
    .ucs_hit_o (ucs_hit),
    .lcs_hit_o (lcs_hit),
    .mcs_hit_o (mcs_hit)
  );

  cs_io_decode #(.IO_W(IO_W), .N_PCS(N_PCS)) u_io (
    .pio_i     (pio_cfg),
    .addr_i    (addr_i[IO_W-1:0]),
    .pcs_hit_o (pcs_hit)
  );

  assign take = ale_i && !hold_i;

  always_comb begin
    pcs_nxt = ~(pcs_hit & {N_PCS{!mem_io_i}});
    if (lat_cfg[0]) pcs_nxt[A1_IDX] = addr_i[1];
    if (lat_cfg[1]) pcs_nxt[A2_IDX] = addr_i[2];
  end

  // outputs hold between strobes and throughout bus hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucs_no <= 1'b1;
      lcs_no <= 1'b1;
      mcs_no <= '1;
      pcs_no <= '1;
    end else if (take) begin
      ucs_no <= !(mem_io_i && ucs_hit);
      lcs_no <= !(mem_io_i && lcs_hit);
      mcs_no <= ~(mcs_hit & {N_MID{mem_io_i}});
      pcs_no <= pcs_nxt;
    end
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_i,
  input logic       mem_io_i,
  input logic       hold_i,
  input logic       ucs_no,
  input logic       lcs_no,
  input logic [3:0] mcs_no,
  input logic [6:0] pcs_no
);
  logic [12:0] outs;
  assign outs = {ucs_no, lcs_no, mcs_no, pcs_no};

  assert_mem_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{ucs_no, lcs_no, mcs_no}));

  assert_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(outs));

  assert_hold_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(outs));

  assert_io_no_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_i && !hold_i && !mem_io_i) |=> (ucs_no && lcs_no && (&mcs_no)));

  assert_mem_no_pio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_i && !hold_i && mem_io_i) |=> (&pcs_no[4:0]));
endmodule

bind chip_sel_top cs_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ale_i    (ale_i),
  .mem_io_i (mem_io_i),
  .hold_i   (hold_i),
  .ucs_no   (ucs_no),
  .lcs_no   (lcs_no),
  .mcs_no   (mcs_no),
  .pcs_no   (pcs_no)
);

// File: tb/sim_chip_sel_top.sv
`timescale 1ns/1ps
module sim_chip_sel_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic [19:0] addr_i = '0;
  logic        ale_i = 1'b0;
  logic        mem_io_i = 1'b0;
  logic        hold_i = 1'b0;
  logic        ucs_no, lcs_no;
  logic [3:0]  mcs_no;
  logic [6:0]  pcs_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] sh [0:4];
  logic [12:0] exp_out = 13'h1FFF;

  always #2 clk_i = ~clk_i;

  chip_sel_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .addr_i(addr_i), .ale_i(ale_i), .mem_io_i(mem_io_i),
    .hold_i(hold_i), .ucs_no(ucs_no), .lcs_no(lcs_no), .mcs_no(mcs_no), .pcs_no(pcs_no)
  );

  function automatic logic [12:0] model(input logic [19:0] a, input logic mem);
    int ai, k, b;
    logic u, l;
    logic [3:0] mc;
    logic [6:0] pc;
    ai = int'(a); u = 1'b1; l = 1'b1; mc = 4'hF; pc = 7'h7F;
    if (mem) begin
      k = int'(sh[0][3:0]);
      if (sh[0][15] && k <= 8 && (ai >> (10 + k)) == ((1 << (10 - k)) - 1)) u = 1'b0;
      k = int'(sh[1][3:0]);
      if (u && sh[1][15] && k <= 8 && (ai >> (10 + k)) == 0) l = 1'b0;
      k = int'(sh[2][10:8]); b = int'(sh[2][6:0]);
      if (u && l && sh[2][15] && k <= 6 && (b % (1 << k)) == 0 && (ai >> (13 + k)) == (b >> k))
        mc[(ai >> (11 + k)) & 3] = 1'b0;
    end else begin
      if (sh[3][15] && a[15:10] == sh[3][5:0] && a[9:7] != 3'd7) pc[a[9:7]] = 1'b0;
    end
    if (sh[4][0]) pc[5] = a[1];
    if (sh[4][1]) pc[6] = a[2];
    return {u, l, mc, pc};
  endfunction

  task automatic check(input string tag);
    logic [12:0] act;
    act = {ucs_no, lcs_no, mcs_no, pcs_no};
    checks++;
    if (act !== exp_out) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_out);
    end
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic step(input logic we, input logic [2:0] wa, input logic [15:0] wd,
                      input logic [19:0] a, input logic ale, input logic mem,
                      input logic hold, input string tag);
    cfg_we_i = we; cfg_addr_i = wa; cfg_data_i = wd;
    addr_i = a; ale_i = ale; mem_io_i = mem; hold_i = hold;
    if (ale && !hold) exp_out = model(a, mem);
    if (we && wa <= 3'd4) sh[wa] = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic wr(input logic [2:0] wa, input logic [15:0] wd);
    step(1'b1, wa, wd, 20'h0, 1'b0, 1'b1, 1'b0, "cfg");
  endtask

  task automatic rd(input logic [19:0] a, input logic mem, input string tag);
    step(1'b0, 3'd0, 16'h0, a, 1'b1, mem, 1'b0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) sh[i] = '0;
    void'($urandom(32'h5EED_0C5));
    repeat (3) @(negedge clk_i);
    exp_out = 13'h1FFF;
    check("R1 in reset");
    rst_ni = 1'b1;
    rd(20'hFFFFF, 1'b1, "R1 nothing enabled mem");
    rd(20'h00000, 1'b0, "R1 nothing enabled io");

    wr(3'd0, 16'h8002);
    rd(20'hFF000, 1'b1, "R2 upper 4K hit");
    rd(20'hFEFFF, 1'b1, "R2 upper 4K miss");
    wr(3'd0, 16'h8009);
    rd(20'hFFFFF, 1'b1, "R5 upper code 9 disabled");

    wr(3'd1, 16'h8000);
    rd(20'h003FF, 1'b1, "R3 lower 1K hit");
    rd(20'h00400, 1'b1, "R3 lower 1K miss");

    wr(3'd2, 16'h8110);
    rd(20'h20000, 1'b1, "R4 mid quarter 0");
    rd(20'h23000, 1'b1, "R4 mid quarter 3");
    rd(20'h24000, 1'b1, "R4 mid outside");
    wr(3'd2, 16'h8111);
    rd(20'h20000, 1'b1, "R5 mid misaligned");
    wr(3'd2, 16'h8710);
    rd(20'h20000, 1'b1, "R5 mid code 7");

    wr(3'd0, 16'h8008);
    wr(3'd2, 16'h8060);
    rd(20'hC0000, 1'b1, "R6 upper over mid");
    wr(3'd1, 16'h8008);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h8000);
    rd(20'h01000, 1'b1, "R6 lower over mid");

    wr(3'd3, 16'h8004);
    rd(20'h01080, 1'b0, "R7 peripheral slot 1");
    rd(20'h01380, 1'b0, "R7 peripheral slot 7 none");
    rd(20'h01080, 1'b1, "R7 memory cycle no peripheral");
    rd(20'h01000, 1'b0, "R7 io cycle no memory");

    wr(3'd4, 16'h0003);
    rd(20'h01282, 1'b0, "R8 slot 5 replaced by A1");
    rd(20'h7FFF4, 1'b1, "R8 latched A2 on memory cycle");
    step(1'b1, 3'd5, 16'hFFFF, 20'h0, 1'b0, 1'b1, 1'b0, "R8 reg 5 ignored");
    rd(20'h01280, 1'b0, "R8 reg 5 ignored, slot 5 still A1");

    step(1'b1, 3'd3, 16'h8010, 20'h01080, 1'b1, 1'b0, 1'b0, "R9 write with strobe uses old cfg");
    rd(20'h01080, 1'b0, "R9 new cfg on next strobe");
    step(1'b0, 3'd0, 16'h0, 20'h04000, 1'b0, 1'b0, 1'b0, "R9 no strobe stable");
    step(1'b0, 3'd0, 16'h0, 20'h04086, 1'b1, 1'b0, 1'b1, "R10 strobe under hold ignored");
    step(1'b0, 3'd0, 16'h0, 20'h00000, 1'b1, 1'b1, 1'b1, "R10 hold keeps latched A1 A2");

    for (int n = 0; n < 3000; n++) begin
      logic we, ale, mem, hold;
      logic [2:0] wa;
      logic [15:0] wd;
      logic [19:0] a;
      we   = ($urandom % 4) == 0;
      wa   = 3'($urandom % 8);
      wd   = 16'($urandom) & 16'h87FF;
      if ($urandom % 4 != 0) wd[15] = 1'b1;
      if ($urandom % 2 == 0) wd[10:8] = 3'($urandom % 3);
      a    = 20'($urandom);
      ale  = ($urandom % 4) != 0;
      mem  = $urandom % 2;
      hold = ($urandom % 8) == 0;
      step(we, wa, wd, a, ale, mem, hold, "random mix");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule